// File: doc/BRIEF.md
# Indexed Palette Colour Table

This block is a colour lookup table for a pseudo-colour display path. It has 256 regular entries and 4 overlay entries, and each entry holds an 8-bit red, an 8-bit green and an 8-bit blue value. A host programs the table through a 32-bit word interface, one component per access. The host first loads an index, then moves through red, green and blue. After the blue access the index steps to the next entry, so a whole palette loads as one unbroken stream of data writes.

A second port serves the pixel pipeline. It takes an 8-bit pixel index, or a 2-bit overlay index when the overlay select is high, and returns the 24-bit colour combinationally. Reset loads a fixed default palette, so the pipeline has a sensible cursor and foreground colour before software writes any entry.

Top module: `pal_lut_top`

## Requirements
- R1: A host write to byte offset 0 loads the entry index from data bits 31:24 and returns the component phase to red (phase code 0). The stored colours do not change.
- R2: Host writes to offset 4 store data bits 31:24 into the regular entry at the current index. Successive writes go to red, then green, then blue (phase codes 0, 1, 2). Data bits 23:0 are ignored.
- R3: The access that completes the blue component steps the index by one, modulo 256, and returns the phase to red.
- R4: Host writes to offset 12 follow the same phase order and the same index step as offset 4. They store into overlay entry (index mod 4) and leave the regular entries unchanged.
- R5: A host read (host_rd high, host_wr low) returns the current component of the regular entry at the current index in bits 31:24, with bits 23:0 zero. It then advances phase and index exactly as a data write does. The read data is valid in the cycle host_rd is high.
- R6: After reset the index is 0 and the phase is red. Every colour is black (0x000000) except regular entry 255 and overlay entries 0 and 2, which are white (0xFFFFFF).
- R7: A host write to any offset other than 0, 4 or 12 changes no colour, no index and no phase.
- R8: The lookup output is combinational and packed as red in 23:16, green in 15:8 and blue in 7:0. With lut_ovl low it shows regular entry lut_idx; with lut_ovl high it shows overlay entry lut_ovl_idx. A host write appears on the output after the clock edge that accepts the write, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one access per cycle |
| host_rd | input | 1 | Host read strobe (a write in the same cycle takes precedence) |
| host_off | input | 4 | Host byte offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, zero when host_rd is low |
| lut_idx | input | 8 | Pixel index for the lookup port |
| lut_ovl | input | 1 | Selects an overlay entry on the lookup port |
| lut_ovl_idx | input | 2 | Overlay index for the lookup port |
| lut_rgb | output | 24 | Looked-up colour {red, green, blue} |

## Verification
A wrong phase or a wrong index shows on the very next data access. The component lands in the wrong byte or the wrong entry, and the lookup port exposes this one cycle later. A host read returns a component of a neighbouring entry at once. A wrong step at the end of a triplet corrupts every later entry in a streamed palette load. The bench therefore loads and reads back the full table in one stream and checks every entry. It also checks entries next to the overlay and control accesses, to catch stray writes.

// File: rtl/pal_pkg.sv
package pal_pkg;
    typedef enum logic [1:0] {
        PH_RED = 2'd0,
        PH_GRN = 2'd1,
        PH_BLU = 2'd2
    } phase_e;
endpackage

// File: rtl/pal_seq.sv
module pal_seq
    import pal_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int OFF_W  = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [OFF_W-1:0]  host_off,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [IDX_W-1:0]  idx_o,
    output phase_e            ph_o,
    output logic              reg_we,
    output logic              ovl_we
);
    localparam logic [OFF_W-1:0] OFF_IDX = OFF_W'(0);
    localparam logic [OFF_W-1:0] OFF_REG = OFF_W'(4);
    localparam logic [OFF_W-1:0] OFF_OVL = OFF_W'(12);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        phase_e           ph;
    } seq_t;

    seq_t st_d, st_q;
    logic step;

    always_comb begin
        st_d   = st_q;
        reg_we = 1'b0;
        ovl_we = 1'b0;
        step   = 1'b0;
        if (host_wr) begin
            unique case (host_off)
                OFF_IDX: begin
                    st_d.idx = host_wdata[DATA_W-1 -: IDX_W];
                    st_d.ph  = PH_RED;
                end
                OFF_REG: begin
                    reg_we = 1'b1;
                    step   = 1'b1;
                end
                OFF_OVL: begin
                    ovl_we = 1'b1;
                    step   = 1'b1;
                end
                default: ;
            endcase
        end else if (host_rd) begin
            step = 1'b1;
        end
        if (step) begin
            unique case (st_q.ph)
                PH_RED: st_d.ph = PH_GRN;
                PH_GRN: st_d.ph = PH_BLU;
                default: begin
                    st_d.ph  = PH_RED;
                    st_d.idx = st_q.idx + 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{idx: '0, ph: PH_RED};
        end else begin
            st_q <= st_d;
        end
    end

    assign idx_o = st_q.idx;
    assign ph_o  = st_q.ph;
endmodule

// File: rtl/pal_store.sv
module pal_store
    import pal_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int COMP_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [IDX_W-1:0]    wr_idx,
    input  phase_e              wr_ph,
    input  logic [COMP_W-1:0]   wr_comp,
    input  logic [IDX_W-1:0]    lut_idx,
    output logic [3*COMP_W-1:0] lut_rgb,
    output logic [3*COMP_W-1:0] host_rgb
);
    localparam int N_ENT  = 1 << IDX_W;
    localparam int RGB_W  = 3 * COMP_W;
    localparam int WHITE  = N_ENT - 1;

    logic [RGB_W-1:0] ent_q [N_ENT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_ENT; i++) begin
                ent_q[i] <= (i == WHITE) ? {RGB_W{1'b1}} : {RGB_W{1'b0}};
            end
        end else if (we) begin
            unique case (wr_ph)
                PH_RED:  ent_q[wr_idx][RGB_W-1 -: COMP_W]        <= wr_comp;
                PH_GRN:  ent_q[wr_idx][RGB_W-COMP_W-1 -: COMP_W] <= wr_comp;
                default: ent_q[wr_idx][COMP_W-1:0]                <= wr_comp;
            endcase
        end
    end

    assign lut_rgb  = ent_q[lut_idx];
    assign host_rgb = ent_q[wr_idx];
endmodule

// File: rtl/pal_ovl.sv
module pal_ovl
    import pal_pkg::*;
#(
    parameter int          OVL_W     = 2,
    parameter int          COMP_W    = 8,
    parameter logic [31:0] WHITE_MAP = 32'h0000_0005
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [OVL_W-1:0]    wr_sel,
    input  phase_e              wr_ph,
    input  logic [COMP_W-1:0]   wr_comp,
    input  logic [OVL_W-1:0]    lut_sel,
    output logic [3*COMP_W-1:0] lut_rgb
);
    localparam int N_OVL = 1 << OVL_W;
    localparam int RGB_W = 3 * COMP_W;

    logic [RGB_W-1:0] ent_all [N_OVL];

    for (genvar k = 0; k < N_OVL; k++) begin : g_ent
        logic [RGB_W-1:0] ent_d, ent_q;

        always_comb begin
            ent_d = ent_q;
            if (we && (wr_sel == OVL_W'(k))) begin
                unique case (wr_ph)
                    PH_RED:  ent_d[RGB_W-1 -: COMP_W]        = wr_comp;
                    PH_GRN:  ent_d[RGB_W-COMP_W-1 -: COMP_W] = wr_comp;
                    default: ent_d[COMP_W-1:0]                = wr_comp;
                endcase
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_q <= WHITE_MAP[k] ? {RGB_W{1'b1}} : {RGB_W{1'b0}};
            end else begin
                ent_q <= ent_d;
            end
        end

        assign ent_all[k] = ent_q;
    end

    assign lut_rgb = ent_all[lut_sel];
endmodule

// File: rtl/pal_lut_top.sv
module pal_lut_top
    import pal_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int COMP_W = 8,
    parameter int OVL_W  = 2,
    parameter int OFF_W  = 4,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_wr,
    input  logic                host_rd,
    input  logic [OFF_W-1:0]    host_off,
    input  logic [DATA_W-1:0]   host_wdata,
    output logic [DATA_W-1:0]   host_rdata,
    input  logic [IDX_W-1:0]    lut_idx,
    input  logic                lut_ovl,
    input  logic [OVL_W-1:0]    lut_ovl_idx,
    output logic [3*COMP_W-1:0] lut_rgb
);
    localparam int RGB_W = 3 * COMP_W;
    localparam int PAD_W = DATA_W - COMP_W;

    logic [IDX_W-1:0]  seq_idx;
    phase_e            seq_ph;
    logic              reg_we, ovl_we;
    logic [COMP_W-1:0] wr_comp;
    logic [RGB_W-1:0]  reg_rgb, ovl_rgb, host_rgb;
    logic [COMP_W-1:0] host_comp;

    assign wr_comp = host_wdata[DATA_W-1 -: COMP_W];

    pal_seq #(.IDX_W(IDX_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .host_wr(host_wr), .host_rd(host_rd),
        .host_off(host_off), .host_wdata(host_wdata),
        .idx_o(seq_idx), .ph_o(seq_ph),
        .reg_we(reg_we), .ovl_we(ovl_we)
    );

    pal_store #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .we(reg_we), .wr_idx(seq_idx), .wr_ph(seq_ph), .wr_comp(wr_comp),
        .lut_idx(lut_idx), .lut_rgb(reg_rgb), .host_rgb(host_rgb)
    );

    pal_ovl #(.OVL_W(OVL_W), .COMP_W(COMP_W)) u_ovl (
        .clk(clk), .rst_n(rst_n),
        .we(ovl_we), .wr_sel(seq_idx[OVL_W-1:0]), .wr_ph(seq_ph),
        .wr_comp(wr_comp), .lut_sel(lut_ovl_idx), .lut_rgb(ovl_rgb)
    );

    always_comb begin
        unique case (seq_ph)
            PH_RED:  host_comp = host_rgb[RGB_W-1 -: COMP_W];
            PH_GRN:  host_comp = host_rgb[RGB_W-COMP_W-1 -: COMP_W];
            default: host_comp = host_rgb[COMP_W-1:0];
        endcase
    end

    assign host_rdata = host_rd ? {host_comp, {PAD_W{1'b0}}} : '0;
    assign lut_rgb    = lut_ovl ? ovl_rgb : reg_rgb;
endmodule

// File: rtl/pal_lut_chk.sv
module pal_lut_chk #(
    parameter int IDX_W  = 8,
    parameter int OFF_W  = 4,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_wr,
    input logic              host_rd,
    input logic [OFF_W-1:0]  host_off,
    input logic [DATA_W-1:0] host_wdata,
    input logic [DATA_W-1:0] host_rdata,
    input logic [IDX_W-1:0]  idx,
    input logic [1:0]        ph
);
    localparam int PAD_W = DATA_W - 8;
    logic data_acc, ign_acc;
    assign data_acc = host_wr && (host_off == OFF_W'(4) || host_off == OFF_W'(12));
    assign ign_acc  = host_wr && host_off != OFF_W'(0) && !data_acc;

    assert_idx_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr && host_off == OFF_W'(0) |=>
            idx == $past(host_wdata[DATA_W-1 -: IDX_W]) && ph == 2'd0);

    assert_phase_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        data_acc && ph == 2'd0 |=> ph == 2'd1 && $stable(idx));

    assert_phase_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ph != 2'd3);

    assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        data_acc && ph == 2'd2 |=> idx == IDX_W'($past(idx) + 1'b1) && ph == 2'd0);

    assert_rd_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd && !host_wr && ph == 2'd2 |=> idx == IDX_W'($past(idx) + 1'b1) && ph == 2'd0);

    assert_rd_low_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        host_rdata[PAD_W-1:0] == '0);

    assert_reset_state_R6: assert property (@(posedge clk)
        !rst_n |=> idx == '0 && ph == 2'd0);

    assert_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ign_acc |=> $stable(idx) && $stable(ph));
endmodule

bind pal_lut_top pal_lut_chk #(.IDX_W(IDX_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_off(host_off), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .idx(seq_idx), .ph(seq_ph)
);

// File: tb/tb_pal_lut_top.sv
module tb_pal_lut_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        host_wr, host_rd;
    logic [3:0]  host_off;
    logic [31:0] host_wdata, host_rdata;
    logic [7:0]  lut_idx;
    logic        lut_ovl;
    logic [1:0]  lut_ovl_idx;
    logic [23:0] lut_rgb;

    int checks = 0;
    int fails  = 0;
    logic [23:0] m_reg [256];
    logic [23:0] m_ovl [4];
    int m_idx, m_ph;

    always #4 clk = ~clk;

    pal_lut_top dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_off(host_off), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .lut_idx(lut_idx), .lut_ovl(lut_ovl), .lut_ovl_idx(lut_ovl_idx),
        .lut_rgb(lut_rgb)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] comp_of(logic [23:0] rgb, int ph);
        return rgb[23-8*ph -: 8];
    endfunction

    task automatic step_model();
        if (m_ph == 2) begin
            m_ph  = 0;
            m_idx = (m_idx + 1) % 256;
        end else begin
            m_ph = m_ph + 1;
        end
    endtask

    task automatic host_write(logic [3:0] off, logic [31:0] data);
        @(negedge clk);
        host_wr = 1'b1; host_off = off; host_wdata = data;
        @(posedge clk);
        #1 host_wr = 1'b0;
        if (off == 4'd0) begin
            m_idx = int'(data[31:24]); m_ph = 0;
        end else if (off == 4'd4) begin
            m_reg[m_idx][23-8*m_ph -: 8] = data[31:24]; step_model();
        end else if (off == 4'd12) begin
            m_ovl[m_idx % 4][23-8*m_ph -: 8] = data[31:24]; step_model();
        end
    endtask

    task automatic host_read(string req);
        @(negedge clk);
        host_rd = 1'b1;
        #1 chk(req, host_rdata, {comp_of(m_reg[m_idx], m_ph), 24'h0});
        @(posedge clk);
        #1 host_rd = 1'b0;
        step_model();
    endtask

    task automatic look_reg(string req, int i);
        @(negedge clk);
        lut_ovl = 1'b0; lut_idx = 8'(i);
        #1 chk(req, {8'h0, lut_rgb}, {8'h0, m_reg[i]});
    endtask

    task automatic look_ovl(string req, int i);
        @(negedge clk);
        lut_ovl = 1'b1; lut_ovl_idx = 2'(i);
        #1 chk(req, {8'h0, lut_rgb}, {8'h0, m_ovl[i]});
        lut_ovl = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; host_wr = 1'b0; host_rd = 1'b0; host_off = '0;
        host_wdata = '0; lut_idx = '0; lut_ovl = 1'b0; lut_ovl_idx = '0;
        for (int i = 0; i < 256; i++) m_reg[i] = (i == 255) ? 24'hFFFFFF : 24'h0;
        for (int i = 0; i < 4; i++) m_ovl[i] = (i == 0 || i == 2) ? 24'hFFFFFF : 24'h0;
        m_idx = 0; m_ph = 0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R6 reset contents on the lookup port
        for (int i = 0; i < 256; i++) look_reg("R6", i);
        for (int i = 0; i < 4; i++) look_ovl("R6", i);
        // R6 index 0 / phase red: first data write lands in entry 0 red
        host_write(4'd4, 32'h12FFFFFF);
        look_reg("R6", 0);
        host_write(4'd4, 32'h34000000);
        host_write(4'd4, 32'h56000000);
        look_reg("R2", 0);

        // R5 reads across the white entry and index wrap
        host_write(4'd0, 32'hFE000000);
        for (int i = 0; i < 7; i++) host_read("R5");

        // R2 R3 R8 exhaustive streamed load with junk in low bits
        host_write(4'd0, 32'h00000000);
        for (int i = 0; i < 256; i++) begin
            host_write(4'd4, {8'(i), 24'hA5C3F1 ^ 24'(i)});
            host_write(4'd4, {8'(i) ^ 8'h5A, 24'h00FF00});
            host_write(4'd4, {8'(255 - i), 24'h123456});
        end
        chk("R3", 32'(m_idx), 32'd0);
        for (int i = 0; i < 256; i++) look_reg("R8", i);
        // R5 streamed readback of the whole table
        for (int i = 0; i < 768; i++) host_read("R5");

        // R1 reload mid-triplet resets phase to red
        host_write(4'd0, 32'h0A000000);
        host_write(4'd4, 32'h11000000);
        host_write(4'd4, 32'h22000000);
        host_write(4'd0, 32'h0AFFFFFF);
        host_write(4'd4, 32'h33000000);
        look_reg("R1", 10);
        look_reg("R1", 11);

        // R4 overlay entries via offset 12, regular entries untouched
        for (int k = 0; k < 4; k++) begin
            host_write(4'd0, {8'(252 + k), 24'h0});
            host_write(4'd12, {8'(16 * k + 1), 24'hFFFFFF});
            host_write(4'd12, {8'(16 * k + 2), 24'h0});
            host_write(4'd12, {8'(16 * k + 3), 24'h0});
            look_ovl("R4", k);
            look_reg("R4", 252 + k);
        end
        // R4 index stepped past 255 to 0 after last overlay triplet
        host_write(4'd4, 32'hC7000000);
        look_reg("R4", 0);

        // R7 ignored offsets keep phase, index and colours
        host_write(4'd0, 32'h14000000);
        host_write(4'd4, 32'h77000000);
        host_write(4'd8, 32'hDE000000);
        host_write(4'd1, 32'hDE000000);
        host_write(4'd14, 32'h99000000);
        look_reg("R7", 222);
        look_reg("R7", 20);
        host_write(4'd4, 32'h88000000);
        look_reg("R7", 20);
        for (int i = 0; i < 4; i++) look_ovl("R7", i);

        // R8 write visible only after the accepting edge
        host_write(4'd0, 32'h30000000);
        @(negedge clk);
        lut_ovl = 1'b0; lut_idx = 8'h30;
        host_wr = 1'b1; host_off = 4'd4; host_wdata = 32'hEE000000;
        #1 chk("R8", {8'h0, lut_rgb}, {8'h0, m_reg[48]});
        @(posedge clk);
        #1 host_wr = 1'b0;
        m_reg[48][23:16] = 8'hEE; step_model();
        chk("R8", {8'h0, lut_rgb}, {8'h0, m_reg[48]});

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule